// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital core of a processor supervisor. It merges three sources into one reset output. The first is a power-up hold. The second is a supply-good bit from an external comparator. The third is a watchdog that the processor must restart with a one-cycle strobe. When the block comes out of its own reset, and again whenever the supply returns after a brown-out, the reset output stays active for a fixed hold time. That time is counted in ticks of a prescaled system clock.

A two-bit interval select picks one of three watchdog intervals, or turns the watchdog off. If the processor does not restart the watchdog within the selected interval, reset is asserted for the same hold time. After that the watchdog starts counting again from zero. A single tick counter serves both the hold time and the watchdog. The supply-good bit is taken through a two-flop synchroniser. The output polarity is chosen by a build parameter.

Top module: `supv_reset_core`

## Requirements
- R1: After `rstN` is released with the supply good, `resetOut` stays active for HOLD_TICKS prescaler ticks (one tick every PRESCALE clocks), give or take one tick, and is then released.
- R2: A low level on `supplyGoodIn` makes `resetOut` active on the third rising clock edge after it is sampled low, and `resetOut` stays active for as long as the input stays low.
- R3: When the supply returns, `resetOut` stays active for the hold time counted from the return. A new drop during that hold restarts the hold time from zero.
- R4: With `wdSel` = 2'b10, a watchdog that is not restarted asserts `resetOut` after WD_SHORT ticks (within one tick). The resulting pulse lasts one hold time.
- R5: With `wdSel` = 2'b01 the expiry comes after WD_MID ticks. With `wdSel` = 2'b00 it comes after WD_LONG ticks. Each is accurate to within one tick.
- R6: With `wdSel` = 2'b11 the watchdog is off: without any `kick`, `resetOut` stays inactive indefinitely.
- R7: A one-cycle `kick` restarts the watchdog interval. Kicks spaced closer than the interval keep `resetOut` inactive.
- R8: A `kick` while reset is active has no effect on the length of the pulse. After a watchdog pulse ends, the next expiry is a full interval after the release.
- R9: With ACTIVE_LOW = 1 the active level of `resetOut` is 0, otherwise it is 1. `resetOut` is active while `rstN` is low.
- R10: `supplyGoodIn` passes through two flops: `resetOut` is still inactive two rising edges after the input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low block reset (power applied when high) |
| supplyGoodIn | input | 1 | Supply above trip point, asynchronous to clk |
| kick | input | 1 | One-cycle watchdog restart strobe |
| wdSel | input | 2 | Stored interval select: 00 long, 01 mid, 10 short, 11 off |
| resetOut | output | 1 | Reset to the processor, polarity set by ACTIVE_LOW |

## Verification
The bench measures every reset pulse and every expiry delay in clock cycles. A design that takes the hold length from the watchdog select, or the reverse, gives pulses or delays outside the one-tick window. Kicks sent during a watchdog pulse would stretch that pulse if they reached the shared counter. A glitch in the supply during the hold must restart the hold, and a design that keeps counting releases the reset too early. The exact edge at which a supply drop shows up on the output shows whether the synchroniser has the wrong depth. A long idle period with the watchdog off catches a design that decodes the disable code wrongly.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} supvState_t;

  typedef struct packed {
    logic clr;
    logic inc;
    logic selHold;
  } cntCtl_t;
endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int PRESCALE   = 4,
  parameter int HOLD_TICKS = 5,
  parameter int WD_LONG    = 12,
  parameter int WD_MID     = 8,
  parameter int WD_SHORT   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGoodIn,
  input  logic [1:0] wdSel,
  input  cntCtl_t    ctl,
  output logic       sgSync,
  output logic       lastTick
);
  localparam int PRE_W  = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int MAX_AB = (WD_LONG > WD_MID) ? WD_LONG : WD_MID;
  localparam int MAX_CD = (WD_SHORT > HOLD_TICKS) ? WD_SHORT : HOLD_TICKS;
  localparam int MAXLIM = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W  = $clog2(MAXLIM + 1);

  logic             sgMeta;
  logic [PRE_W-1:0] preCnt;
  logic             tick;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sgMeta <= 1'b0;
      sgSync <= 1'b0;
    end else begin
      sgMeta <= supplyGoodIn;
      sgSync <= sgMeta;
    end
  end

  assign tick = (preCnt == PRE_W'(PRESCALE - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     preCnt <= '0;
    else if (tick) preCnt <= '0;
    else           preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    if (ctl.selHold) limit = CNT_W'(HOLD_TICKS);
    else begin
      case (wdSel)
        2'b00:   limit = CNT_W'(WD_LONG);
        2'b01:   limit = CNT_W'(WD_MID);
        default: limit = CNT_W'(WD_SHORT);
      endcase
    end
  end

  assign lastTick = tick && (cnt >= limit - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (ctl.clr)         cnt <= '0;
    else if (ctl.inc && tick) cnt <= cnt + 1'b1;
  end

  // R7
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.clr |=> (cnt == '0));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(MAXLIM));
endmodule

// File: rtl/supv_ctrl.sv
module supv_ctrl
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sgSync,
  input  logic       lastTick,
  input  logic       kick,
  input  logic [1:0] wdSel,
  output cntCtl_t    ctl,
  output logic       inHold
);
  supvState_t state, stateNext;
  logic       wdOff;

  assign wdOff  = (wdSel == 2'b11);
  assign inHold = (state == ST_HOLD);

  always_comb begin
    stateNext   = state;
    ctl.clr     = 1'b0;
    ctl.inc     = 1'b0;
    ctl.selHold = (state == ST_HOLD);
    if (state == ST_HOLD) begin
      if (!sgSync) ctl.clr = 1'b1;
      else if (lastTick) begin
        stateNext = ST_RUN;
        ctl.clr   = 1'b1;
      end else ctl.inc = 1'b1;
    end else begin
      if (!sgSync) begin
        stateNext = ST_HOLD;
        ctl.clr   = 1'b1;
      end else if (kick || wdOff) ctl.clr = 1'b1;
      else if (lastTick) begin
        stateNext = ST_HOLD;
        ctl.clr   = 1'b1;
      end else ctl.inc = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HOLD;
    else       state <= stateNext;
  end

  // R2
  brownout_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inHold && !sgSync) |=> inHold);

  // R6
  wd_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!inHold && sgSync && wdSel == 2'b11) |=> !inHold);

  // R1
  release_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(inHold) |-> $past(lastTick && sgSync));
endmodule

// File: rtl/supv_reset_core.sv
module supv_reset_core #(
  parameter int PRESCALE   = 4,
  parameter int HOLD_TICKS = 5,
  parameter int WD_LONG    = 12,
  parameter int WD_MID     = 8,
  parameter int WD_SHORT   = 4,
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGoodIn,
  input  logic       kick,
  input  logic [1:0] wdSel,
  output logic       resetOut
);
  supv_pkg::cntCtl_t ctl;
  logic sgSync, lastTick, inHold;

  supv_datapath #(
    .PRESCALE(PRESCALE), .HOLD_TICKS(HOLD_TICKS),
    .WD_LONG(WD_LONG), .WD_MID(WD_MID), .WD_SHORT(WD_SHORT)
  ) uDp (
    .clk(clk), .rstN(rstN), .supplyGoodIn(supplyGoodIn), .wdSel(wdSel),
    .ctl(ctl), .sgSync(sgSync), .lastTick(lastTick)
  );

  supv_ctrl uCtl (
    .clk(clk), .rstN(rstN), .sgSync(sgSync), .lastTick(lastTick),
    .kick(kick), .wdSel(wdSel), .ctl(ctl), .inHold(inHold)
  );

  generate
    if (ACTIVE_LOW) begin : gPolLow
      assign resetOut = ~inHold;
    end else begin : gPolHigh
      assign resetOut = inHold;
    end
  endgenerate
endmodule

// File: tb/sim_supv_reset_core.sv
`timescale 1ns/1ps
module sim_supv_reset_core;
  localparam int P  = 4;
  localparam int H  = 5;
  localparam int WL = 12;
  localparam int WM = 8;
  localparam int WS = 4;
  localparam bit AL = 1'b1;
  localparam logic ACT = AL ? 1'b0 : 1'b1;

  typedef struct {
    string tag;
    int    lo;
    int    hi;
  } pulseExp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGoodIn = 1'b1;
  logic kick = 1'b0;
  logic [1:0] wdSel = 2'b11;
  logic resetOut;

  int nChecks = 0;
  int nFails  = 0;
  pulseExp_t expQ[$];
  int curLen = 0;
  logic wasAct = 1'b0;

  always #5 clk = ~clk;

  supv_reset_core #(
    .PRESCALE(P), .HOLD_TICKS(H), .WD_LONG(WL), .WD_MID(WM),
    .WD_SHORT(WS), .ACTIVE_LOW(AL)
  ) u0 (
    .clk(clk), .rstN(rstN), .supplyGoodIn(supplyGoodIn), .kick(kick),
    .wdSel(wdSel), .resetOut(resetOut)
  );

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic checkRange(input string tag, input int v, input int lo, input int hi);
    nChecks++;
    if (v < lo || v > hi) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, v, lo, hi);
    end
  endtask

  // monitor: measure each active pulse and compare to the scoreboard
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      if (resetOut == ACT) curLen++;
      else if (wasAct) begin
        if (expQ.size() == 0) begin
          nChecks++; nFails++;
          $display("FAIL unexpected pulse actual=%0d expected=none", curLen);
        end else begin
          pulseExp_t e;
          e = expQ.pop_front();
          checkRange(e.tag, curLen, e.lo, e.hi);
        end
        curLen = 0;
      end
      wasAct = (resetOut == ACT);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pushHold(input string tag, input int extra);
    pulseExp_t e;
    e.tag = tag; e.lo = extra + (H - 1) * P - 2; e.hi = extra + H * P + 4;
    expQ.push_back(e);
  endtask

  task automatic waitRelease();
    int n = 0;
    while (resetOut == ACT && n < 2000) begin @(negedge clk); n++; end
    cyc(2);
  endtask

  task automatic pulseKick();
    kick = 1'b1; @(negedge clk); kick = 1'b0;
  endtask

  task automatic delayToActive(output int n);
    n = 0;
    while (resetOut != ACT && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog timeout actual=hung expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int d;
    cyc(3);
    // R9: active level during block reset
    check("R9 reset level", resetOut == ACT, resetOut, ACT);
    pushHold("R1 power-up hold", 0);
    rstN = 1'b1;
    cyc(1);
    check("R1 active after release", resetOut == ACT, resetOut, ACT);
    waitRelease();
    check("R1 released", resetOut != ACT, resetOut, !ACT);

    // R6: watchdog off, no kicks
    wdSel = 2'b11;
    cyc(200);
    check("R6 disabled stays inactive", resetOut != ACT, resetOut, !ACT);

    // R7: periodic kicks with long interval
    wdSel = 2'b00;
    pulseKick();
    for (int i = 0; i < 8; i++) begin
      cyc(30);
      pulseKick();
      check("R7 kicked stays inactive", resetOut != ACT, resetOut, !ACT);
    end

    // R5 long interval, then R8 kicks during hold
    pushHold("R8 hold with kicks", 0);
    pulseKick();
    delayToActive(d);
    checkRange("R5 long expiry", d + 1, (WL - 1) * P, WL * P + 3);
    cyc(5); pulseKick(); cyc(5); pulseKick();
    waitRelease();
    pushHold("R8 second pulse", 0);
    delayToActive(d);
    checkRange("R8 full interval after release", d + 2, (WL - 1) * P, WL * P + 4);
    wdSel = 2'b11;
    waitRelease();

    // R5 mid interval
    wdSel = 2'b01;
    pulseKick();
    pushHold("R5 mid pulse", 0);
    delayToActive(d);
    checkRange("R5 mid expiry", d + 1, (WM - 1) * P, WM * P + 3);
    wdSel = 2'b11;
    waitRelease();

    // R4 short interval
    wdSel = 2'b10;
    pulseKick();
    pushHold("R4 short pulse", 0);
    delayToActive(d);
    checkRange("R4 short expiry", d + 1, (WS - 1) * P, WS * P + 3);
    wdSel = 2'b11;
    waitRelease();

    // R2/R10: brown-out with exact synchroniser latency
    pushHold("R3 brownout hold", 30);
    supplyGoodIn = 1'b0;
    cyc(2);
    check("R10 two-flop latency", resetOut != ACT, resetOut, !ACT);
    cyc(1);
    check("R2 asserted on third edge", resetOut == ACT, resetOut, ACT);
    cyc(26);
    check("R2 held while supply low", resetOut == ACT, resetOut, ACT);
    cyc(1);
    supplyGoodIn = 1'b1;
    waitRelease();
    check("R3 released after hold", resetOut != ACT, resetOut, !ACT);

    // R3: glitch during hold restarts it
    pushHold("R3 glitch restart", 30);
    supplyGoodIn = 1'b0; cyc(10);
    supplyGoodIn = 1'b1; cyc(10);
    check("R3 still held mid-hold", resetOut == ACT, resetOut, ACT);
    supplyGoodIn = 1'b0; cyc(10);
    supplyGoodIn = 1'b1;
    waitRelease();

    cyc(20);
    check("R1 all expected pulses seen", expQ.size() == 0, expQ.size(), 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule